// File: doc/BRIEF.md
# Oversampled Data Clock Recovery Loop

This block recovers a bit clock from a serial NRZ or NRZI data line. It runs on the system clock and is advanced by a tick from one of two oversampling sources. Each count of its 5-bit cycle counter spans two ticks, a first half and a second half, so edges are placed to half-count resolution. One full counter cycle of 32 counts, which is 64 ticks, is one bit cell. The data line is sampled on every selected tick, and a change between two ticks is an edge.

The loop has three states. OFF means disabled: the counter is held and edges are not detected. SEARCH means armed: the counter is held at 16 and no clock pulses are produced. TRACK means locked: the counter runs and one receive pulse and one identical transmit pulse are produced per bit cell. The transitions are as follows:
- OFF to SEARCH on the search command.
- SEARCH to TRACK on the first qualifying edge, which is taken as the boundary between counts 15 and 16.
- TRACK to SEARCH when the search command is issued again.
- Any state to OFF on the disable command.

In TRACK, each edge is compared with the expected boundary. An edge near the boundary is left alone. An early edge removes one count from the current cycle. A late edge adds one count to it.

Top module: `dpll_recover`

## Requirements
- R1: After reset the block is in OFF. rx_en, tx_en and locked are 0. Ticks and data edges in OFF produce no pulse and no lock.
- R2: The search command (cmd_search high for one cycle) enters SEARCH. In SEARCH, locked is 0 and no pulse is produced until the first qualifying edge.
- R3: A qualifying edge in SEARCH, seen on tick E, sets locked to 1 in the cycle after that tick. The first receive pulse follows the tick numbered E+31. Each pulse is high for the one cycle after its tick.
- R4: In TRACK with no further edges, pulses repeat every 64 ticks, which is 32 counts.
- R5: Dead band: an edge whose tick falls in the second half of count 15 or the first half of count 16 changes nothing. After lock on tick E, these are the ticks E+63 and E+64 plus multiples of 64.
- R6: An edge in the early region shortens the cycle by one count, so the next pulse comes 2 ticks early. The early region is counts 0 to 14 and the first half of count 15. An edge in a first half is applied at the end of that count. An edge in a second half is applied at once.
- R7: An edge in the late region lengthens the cycle by one count, so the next pulse comes 2 ticks late. The late region is the second half of count 16 and counts 17 to 31.
- R8: tx_en is identical to rx_en in every cycle.
- R9: Issuing the search command again while in TRACK returns the block to SEARCH. locked falls and pulses stop.
- R10: The disable command (cmd_disable high for one cycle) enters OFF from any state. If both commands are high in the same cycle, disable wins.
- R11: src_sel chooses which bit of tick_src advances the loop: 0 selects bit 0 and 1 selects bit 1. Ticks on the other bit are ignored.
- R12: edge_sel = 0 qualifies both edge directions. edge_sel = 1 qualifies only falling edges (1 to 0), for both locking and correction.
- R13: src_sel and edge_sel are captured only while in OFF. Changes made while in SEARCH or TRACK have no effect.
- R14: When the data boundary starts 9 ticks late of the lock point, the loop enters the dead band after 5 corrections. Pulse m then follows tick E+31+64m+2*min(m,5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_search | input | 1 | One-cycle command: enable and enter search |
| cmd_disable | input | 1 | One-cycle command: disable |
| src_sel | input | 1 | Tick source choice, captured in OFF |
| edge_sel | input | 1 | 0 both edges, 1 falling only, captured in OFF |
| tick_src | input | 2 | Oversampling tick enables, two per count |
| rxd | input | 1 | Serial receive data |
| rx_en | output | 1 | Recovered receive clock enable, one cycle per bit |
| tx_en | output | 1 | Recovered transmit clock enable, equal to rx_en |
| locked | output | 1 | 1 in TRACK, 0 in OFF or SEARCH |

## Verification
Every result is counted in selected ticks, with one register from a tick to its output. locked changes and a pulse shows in the system clock cycle right after the tick that caused it. The first pulse after lock on tick E belongs to tick E+31, and each correction moves all later pulses by 2 ticks. The bench drives one tick per two clock cycles and samples on the falling edge that follows each tick. It tags every pulse with the number of the tick just driven and compares that number with the predicted pulse ticks queued by the driver.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SEARCH = 2'd1,
        ST_TRACK  = 2'd2
    } dpll_state_t;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } dpll_adj_t;
endpackage

// File: rtl/dpll_cfg.sv
module dpll_cfg #(
    parameter int N_SRC = 2,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enabled,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             edge_sel,
    input  logic [N_SRC-1:0] tick_src,
    output logic             tick_o,
    output logic             fall_only_o
);
    logic [SEL_W-1:0] sel_q;
    logic             fall_q;

    // settings follow the pins only while the loop is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            fall_q <= 1'b0;
        end else if (!enabled) begin
            sel_q  <= src_sel;
            fall_q <= edge_sel;
        end
    end

    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel_q == SEL_W'(i)) tick_o = tick_src[i];
        end
    end

    assign fall_only_o = fall_q;

    assert_cfg_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> ($stable(sel_q) && $stable(fall_q)));
endmodule

// File: rtl/dpll_edge.sv
module dpll_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic enabled,
    input  logic arm,
    input  logic tick,
    input  logic rxd,
    input  logic fall_only,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    prev_q <= 1'b0;
        else if (arm)  prev_q <= rxd;
        else if (tick) prev_q <= rxd;
    end

    assign edge_o = enabled && !arm && tick && (rxd != prev_q) && (!fall_only || prev_q);

    assert_fall_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && fall_only) |-> !rxd);
endmodule

// File: rtl/dpll_phase.sv
module dpll_phase import dpll_pkg::*; #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             half,
    output dpll_adj_t        adj_o
);
    localparam logic [CNT_W-1:0] HOLD = CNT_W'(1 << (CNT_W - 1));
    localparam logic [CNT_W-1:0] PRE  = HOLD - CNT_W'(1);

    logic dead, early;

    always_comb begin
        dead  = ((cnt == PRE) && half) || ((cnt == HOLD) && !half);
        early = (cnt < PRE) || ((cnt == PRE) && !half);
        if (dead)       adj_o = ADJ_NONE;
        else if (early) adj_o = ADJ_SHORT;
        else            adj_o = ADJ_LONG;
    end
endmodule

// File: rtl/dpll_core.sv
module dpll_core import dpll_pkg::*; #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_search,
    input  logic             cmd_disable,
    input  logic             tick,
    input  logic             edge_seen,
    input  dpll_adj_t        adj_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             half_o,
    output logic             enabled_o,
    output logic             arm_o,
    output logic             rx_en_o,
    output logic             locked_o
);
    localparam logic [CNT_W-1:0] HOLD = CNT_W'(1 << (CNT_W - 1));

    dpll_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             half_q;
    dpll_adj_t        pend_q, act, eff;
    logic [1:0]       inc;
    logic [CNT_W:0]   sum;
    logic             cmd_any, step, rx_en_q;

    assign cmd_any = cmd_search || cmd_disable;

    // next state
    always_comb begin
        state_d = state_q;
        if (cmd_disable)     state_d = ST_OFF;
        else if (cmd_search) state_d = ST_SEARCH;
        else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_OFF;
                ST_SEARCH: if (edge_seen) state_d = ST_TRACK;
                ST_TRACK:  state_d = ST_TRACK;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // phase step selection
    always_comb begin
        act = edge_seen ? adj_in : ADJ_NONE;
        eff = (act != ADJ_NONE) ? act : pend_q;
        unique case (eff)
            ADJ_SHORT: inc = 2'd2;
            ADJ_LONG:  inc = 2'd0;
            default:   inc = 2'd1;
        endcase
        sum  = {1'b0, cnt_q} + (CNT_W+1)'(inc);
        step = (state_q == ST_TRACK) && tick && half_q && !cmd_any;
    end

    // counter, half-count phase and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= HOLD;
            half_q  <= 1'b0;
            pend_q  <= ADJ_NONE;
            rx_en_q <= 1'b0;
        end else begin
            rx_en_q <= step && sum[CNT_W];
            if (cmd_any || state_q != ST_TRACK) begin
                cnt_q  <= HOLD;
                pend_q <= ADJ_NONE;
                half_q <= (state_d == ST_TRACK);
            end else if (tick) begin
                if (!half_q) begin
                    half_q <= 1'b1;
                    pend_q <= act;
                end else begin
                    half_q <= 1'b0;
                    pend_q <= ADJ_NONE;
                    cnt_q  <= sum[CNT_W-1:0];
                end
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign half_o    = half_q;
    assign enabled_o = (state_q != ST_OFF);
    assign arm_o     = cmd_search;
    assign rx_en_o   = rx_en_q;
    assign locked_o  = (state_q == ST_TRACK);

    assert_quiet_unless_tracking_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_q |-> ($past(state_q) == ST_TRACK));
    assert_lock_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH && edge_seen && !cmd_any) |=> locked_o);
    // R7 as well: a step moves the count by 0, 1 or 2 only
    assert_step_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(2)));
    assert_reenter_search_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_search && !cmd_disable) |=> (state_q == ST_SEARCH && !rx_en_q));
    assert_disable_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disable |=> (state_q == ST_OFF));
endmodule

// File: rtl/dpll_recover.sv
module dpll_recover import dpll_pkg::*; #(
    parameter int CNT_W = 5,
    parameter int N_SRC = 2,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_search,
    input  logic             cmd_disable,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             edge_sel,
    input  logic [N_SRC-1:0] tick_src,
    input  logic             rxd,
    output logic             rx_en,
    output logic             tx_en,
    output logic             locked
);
    logic             tick, fall_only, enabled, arm, edge_seen, half, rx_pulse;
    logic [CNT_W-1:0] cnt;
    dpll_adj_t        adj;

    dpll_cfg #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enabled(enabled), .src_sel(src_sel),
        .edge_sel(edge_sel), .tick_src(tick_src), .tick_o(tick), .fall_only_o(fall_only)
    );

    dpll_edge u_edge (
        .clk(clk), .rst_n(rst_n), .enabled(enabled), .arm(arm), .tick(tick),
        .rxd(rxd), .fall_only(fall_only), .edge_o(edge_seen)
    );

    dpll_phase #(.CNT_W(CNT_W)) u_phase (
        .cnt(cnt), .half(half), .adj_o(adj)
    );

    dpll_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cmd_search(cmd_search), .cmd_disable(cmd_disable),
        .tick(tick), .edge_seen(edge_seen), .adj_in(adj), .cnt_o(cnt), .half_o(half),
        .enabled_o(enabled), .arm_o(arm), .rx_en_o(rx_pulse), .locked_o(locked)
    );

    assign rx_en = rx_pulse;
    assign tx_en = rx_pulse;
endmodule

// File: tb/tb_dpll_recover.sv
module tb_dpll_recover;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_search = 1'b0, cmd_disable = 1'b0;
    logic       src_sel = 1'b0, edge_sel = 1'b0;
    logic [1:0] tick_src = 2'b00;
    logic       rxd = 1'b0;
    logic       rx_en, tx_en, locked;

    int    errors = 0, checks = 0;
    int    tick_no = 0;
    int    e_tick = 0;
    logic  rxd_v = 1'b0;
    logic [1:0] cur_mask = 2'b01;
    string cur_tag = "R1";
    int    exp_q[$];
    string tag_q[$];
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    dpll_recover dut (
        .clk(clk), .rst_n(rst_n), .cmd_search(cmd_search), .cmd_disable(cmd_disable),
        .src_sel(src_sel), .edge_sel(edge_sel), .tick_src(tick_src), .rxd(rxd),
        .rx_en(rx_en), .tx_en(tx_en), .locked(locked)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_pulse(input int t, input string tag);
        exp_q.push_back(t);
        tag_q.push_back(tag);
    endtask

    task automatic drain(input string tag);
        check({tag, " missing pulses"}, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // one tick on the lines in mask; counted ticks advance tick_no
    task automatic tk(input logic [1:0] mask, input bit counted);
        @(negedge clk);
        tick_src = mask;
        rxd = rxd_v;
        if (counted) tick_no++;
        @(negedge clk);
        tick_src = 2'b00;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tk(cur_mask, 1'b1);
    endtask

    task automatic run_to(input int t);
        while (tick_no < t) tk(cur_mask, 1'b1);
    endtask

    task automatic flip();
        rxd_v = ~rxd_v;
        tk(cur_mask, 1'b1);
    endtask

    task automatic cmd(input bit s, input bit d);
        @(negedge clk);
        cmd_search = s;
        cmd_disable = d;
        @(negedge clk);
        cmd_search = 1'b0;
        cmd_disable = 1'b0;
    endtask

    task automatic lock_now(input string tag);
        cmd(1'b1, 1'b0);
        run(5);
        check({tag, " locked before edge"}, locked, 0);
        flip();
        e_tick = tick_no;
        check({tag, " locked after first edge"}, locked, 1);
    endtask

    // monitor: scoreboard pops one predicted tick per observed pulse
    always @(negedge clk) begin
        if (rst_n && !done && (rx_en || tx_en)) begin
            checks++;
            if (rx_en !== tx_en) begin
                errors++;
                $display("FAIL R8 tx_en actual=%0b expected=%0b", tx_en, rx_en);
            end
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected pulse actual=tick %0d expected=none", cur_tag, tick_no);
            end else begin
                automatic int    t  = exp_q.pop_front();
                automatic string tg = tag_q.pop_front();
                if (t != tick_no) begin
                    errors++;
                    $display("FAIL %s pulse actual=tick %0d expected=tick %0d", tg, tick_no, t);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and inactivity in OFF
        cur_tag = "R1";
        check("R1 rx_en after reset", rx_en, 0);
        check("R1 locked after reset", locked, 0);
        for (int i = 0; i < 10; i++) begin flip(); run(3); end
        check("R1 locked in OFF", locked, 0);

        // R2, R3, R4: search, lock, free run
        cur_tag = "R2";
        cmd(1'b1, 1'b0);
        run(100);
        check("R2 locked in SEARCH", locked, 0);
        cur_tag = "R4";
        flip();
        e_tick = tick_no;
        check("R3 locked after first edge", locked, 1);
        expect_pulse(e_tick + 31, "R3");
        expect_pulse(e_tick + 95, "R4");
        expect_pulse(e_tick + 159, "R4");
        run_to(e_tick + 170);
        drain("R4");

        // R5: dead band edges
        cur_tag = "R5";
        lock_now("R5");
        expect_pulse(e_tick + 31, "R5");
        expect_pulse(e_tick + 95, "R5");
        expect_pulse(e_tick + 159, "R5");
        expect_pulse(e_tick + 223, "R5");
        run_to(e_tick + 62); flip();
        run_to(e_tick + 127); flip();
        run_to(e_tick + 230);
        drain("R5");

        // R6: early edge in a first half
        cur_tag = "R6";
        lock_now("R6");
        expect_pulse(e_tick + 31, "R6");
        expect_pulse(e_tick + 93, "R6");
        expect_pulse(e_tick + 157, "R6");
        run_to(e_tick + 61); flip();
        run_to(e_tick + 165);
        drain("R6");

        // R7: late edge in a second half
        cur_tag = "R7";
        lock_now("R7");
        expect_pulse(e_tick + 31, "R7");
        expect_pulse(e_tick + 97, "R7");
        expect_pulse(e_tick + 161, "R7");
        run_to(e_tick + 64); flip();
        run_to(e_tick + 170);

        // R9: reissue search while tracking
        drain("R7");
        cur_tag = "R9";
        cmd(1'b1, 1'b0);
        check("R9 locked after reissue", locked, 0);
        run(100);
        check("R9 locked stays low", locked, 0);

        // R14: convergence from 9 ticks late
        cur_tag = "R14";
        flip();
        e_tick = tick_no;
        for (int m = 0; m <= 10; m++)
            expect_pulse(e_tick + 31 + 64 * m + 2 * ((m < 5) ? m : 5), "R14");
        for (int m = 1; m <= 10; m++) begin
            run_to(e_tick + 9 + 64 * m - 1);
            flip();
        end
        run_to(e_tick + 31 + 640 + 10 + 8);
        drain("R14");
        check("R14 locked", locked, 1);

        // R10: disable, then both commands together
        cur_tag = "R10";
        cmd(1'b0, 1'b1);
        check("R10 locked after disable", locked, 0);
        for (int i = 0; i < 5; i++) begin flip(); run(20); end
        cmd(1'b1, 1'b1);
        flip(); run(80);
        check("R10 disable wins over search", locked, 0);

        // R11: source 1 selected, source 0 ignored
        cur_tag = "R11";
        src_sel = 1'b1;
        cur_mask = 2'b10;
        repeat (3) @(negedge clk);
        lock_now("R11");
        expect_pulse(e_tick + 31, "R11");
        expect_pulse(e_tick + 95, "R11");
        run_to(e_tick + 40);
        rxd_v = ~rxd_v; tk(2'b01, 1'b0);
        for (int i = 0; i < 40; i++) tk(2'b01, 1'b0);
        rxd_v = ~rxd_v; tk(2'b01, 1'b0);
        run_to(e_tick + 100);
        drain("R11");

        // R13: pin changes while tracking are ignored
        cur_tag = "R13";
        src_sel = 1'b0;
        edge_sel = 1'b1;
        expect_pulse(e_tick + 159, "R13");
        expect_pulse(e_tick + 223, "R13");
        run_to(e_tick + 230);
        drain("R13");
        check("R13 still locked", locked, 1);
        cmd(1'b0, 1'b1);

        // R12: falling edges only
        cur_tag = "R12";
        cur_mask = 2'b01;
        src_sel = 1'b0;
        edge_sel = 1'b1;
        rxd_v = 1'b0;
        run(2);
        cmd(1'b1, 1'b0);
        run(5);
        flip();
        run(50);
        check("R12 rising edge ignored in SEARCH", locked, 0);
        flip();
        e_tick = tick_no;
        check("R12 falling edge locks", locked, 1);
        expect_pulse(e_tick + 31, "R12");
        expect_pulse(e_tick + 95, "R12");
        run_to(e_tick + 61); flip();
        run_to(e_tick + 100);
        drain("R12");
        check("R12 rxd level at end", rxd_v, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule